// File: doc/BRIEF.md
# Timed Periodic Pulse Trigger

This block holds a group of trigger units that watch a running time-of-day value (32-bit seconds plus 32-bit nanoseconds). Each unit waits until that time reaches a programmed start instant and then drives a train of positive pulses on an output pin that software selects. For each unit software sets the period in nanoseconds, the high time in 8 ns steps and the number of periods. A period count of zero keeps the train running until it is stopped.

Each unit has done, error and interrupt flags. A flag is cleared by writing a one to its bit. Software sets up a unit with single-cycle writes: it selects the unit with `wr_unit` and the field with `wr_addr`. The field addresses are: 0 start nanoseconds, 1 start seconds, 2 period, 3 high time, 4 period count, 5 control, 6 flag clear. Each period edge is found by adding the period to the previous edge, with a carry into seconds. The edge takes effect on the first time sample that is at or after it. The output changes on the clock edge that samples that time.

Top module: `pulse_trig`

## Requirements
- R1: After reset every pin of `gpio_out` is 0, and for every unit the active, done, error and interrupt flags are 0.
- R2: A write to address 5 with bit 0 set and bit 1 clear arms the unit when the start time is not earlier than the current time, and `unit_active` rises. The pin first rises on the clock edge that samples the first time value at or after the start time.
- R3: After a rise, the pin stays high until the first time sample at or after the rise boundary plus 8 ns times the high-time field written at address 3.
- R4: Each boundary after the first is the previous boundary plus the period written at address 2. The nanoseconds carry into seconds at 10^9, so the pulses stay evenly spaced across a second rollover.
- R5: With a nonzero period count written at address 4, the unit makes exactly that many pulses. At the boundary that ends the last period, `unit_done` is set, `unit_active` clears and the pin is low.
- R6: With a period count of 0, the pulses repeat without end, and `unit_done` stays 0.
- R7: Control bit 2 is the notify option. `unit_irq` is set at completion only when notify is set. `unit_done` is set at completion in both cases.
- R8: Arming with a start time earlier than the current time sets `unit_err`, leaves `unit_active` at 0 and produces no pulse.
- R9: A write to address 6 clears done when bit 0 is 1, error when bit 1 is 1 and interrupt when bit 2 is 1. A 0 in a bit leaves that flag unchanged.
- R10: A write to address 5 with bit 1 set is a trigger reset. It clears `unit_active` at once and holds the unit's pin at the level it had, with no further change.
- R11: Control bits 7:4 choose the output pin for the unit. Pulses appear only on the chosen pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 32 | Current time, nanoseconds (below 10^9) |
| wr_en | input | 1 | Field write strobe |
| wr_unit | input | UNIT_W (2) | Unit selected for the write |
| wr_addr | input | 3 | Field address within the unit |
| wr_data | input | 32 | Write data |
| gpio_out | output | NUM_PINS (4) | Pulse output pins |
| unit_active | output | NUM_UNITS (3) | Unit armed or pulsing |
| unit_done | output | NUM_UNITS (3) | Completion flag |
| unit_err | output | NUM_UNITS (3) | Late-start error flag |
| unit_irq | output | NUM_UNITS (3) | Completion interrupt flag |

## Verification
The assertions assume three things about the inputs. The time input never moves backward between arming and completion, except through an explicit jump made while the watched unit is idle. The nanosecond field is always below 10^9. A control write never sets the reset and arm bits together. The stimulus steps time by 40 ns on every clock, keeps every target and jump on that 40 ns grid, and makes its single time jump only when all units are idle. Every pulse measurement is taken from the pins and flags, and is compared with the tick numbers that the bench derives from its own time model.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

   localparam logic [32:0] NS_PER_SEC = 33'd1_000_000_000;

   typedef struct packed {
      logic [31:0] sec;
      logic [31:0] ns;
   } ptu_time_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RUN
   } ptu_state_e;

   // field addresses inside one unit
   localparam logic [2:0] A_TGT_NS  = 3'd0;
   localparam logic [2:0] A_TGT_SEC = 3'd1;
   localparam logic [2:0] A_CYCLE   = 3'd2;
   localparam logic [2:0] A_PULSE   = 3'd3;
   localparam logic [2:0] A_COUNT   = 3'd4;
   localparam logic [2:0] A_CTRL    = 3'd5;
   localparam logic [2:0] A_STAT    = 3'd6;

   // true when time a is at or after time b (ns normalised below 1e9)
   function automatic logic t_reached(ptu_time_t a, ptu_time_t b);
      return {a.sec, a.ns} >= {b.sec, b.ns};
   endfunction

endpackage

// File: rtl/ptu_time_add.sv
module ptu_time_add
   import ptu_pkg::*;
#(
   parameter int DW = 30
) (
   input  ptu_time_t         base,
   input  logic [DW-1:0]     delta,
   output ptu_time_t         sum
);

   localparam logic [32:0] TWO_SEC = NS_PER_SEC + NS_PER_SEC;

   generate
      if (DW < 1 || DW > 30) begin : g_bad_dw
         $error("ptu_time_add: DW must lie in 1..30");
      end
   endgenerate

   logic [32:0] raw;

   always_comb begin
      raw = {1'b0, base.ns} + 33'(delta);
      if (raw >= TWO_SEC) begin
         sum.ns  = 32'(raw - TWO_SEC);
         sum.sec = base.sec + 32'd2;
      end else if (raw >= NS_PER_SEC) begin
         sum.ns  = 32'(raw - NS_PER_SEC);
         sum.sec = base.sec + 32'd1;
      end else begin
         sum.ns  = raw[31:0];
         sum.sec = base.sec;
      end
   end

endmodule

// File: rtl/ptu_unit.sv
module ptu_unit
   import ptu_pkg::*;
#(
   parameter int CW_W  = 30,
   parameter int PW_W  = 24,
   parameter int CNT_W = 16,
   parameter int GS_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ptu_time_t        now,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [31:0]      wr_data,
   output logic             level_o,
   output logic             active_o,
   output logic             done_o,
   output logic             err_o,
   output logic             irq_o,
   output logic [GS_W-1:0]  gsel_o
);

   localparam int PD_W = PW_W + 3;

   ptu_time_t        tgt_q, nxt_q, hend_q, nxt_d, hend_d;
   logic [CW_W-1:0]  cyc_q;
   logic [PW_W-1:0]  pw_q;
   logic [CNT_W-1:0] cnt_q, ncyc_q;
   logic [GS_W-1:0]  gsel_q;
   logic             notify_q, level_q, done_q, err_q, irq_q;
   ptu_state_e       state_q;

   logic at_bound, at_hend, last_cyc, wr_ctrl, trig_rst, arm, late;
   logic unused_wr;

   assign unused_wr = ^wr_data;

   ptu_time_add #(.DW(CW_W)) u_next (.base(nxt_q), .delta(cyc_q),          .sum(nxt_d));
   ptu_time_add #(.DW(PD_W)) u_high (.base(nxt_q), .delta({pw_q, 3'b000}), .sum(hend_d));

   assign at_bound = t_reached(now, nxt_q);
   assign at_hend  = t_reached(now, hend_q);
   assign last_cyc = (cnt_q != '0) && (ncyc_q == cnt_q);
   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign trig_rst = wr_ctrl && wr_data[1];
   assign arm      = wr_ctrl && !wr_data[1] && wr_data[0];
   assign late     = !t_reached(tgt_q, now);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q    <= '0;
         nxt_q    <= '0;
         hend_q   <= '0;
         cyc_q    <= '0;
         pw_q     <= '0;
         cnt_q    <= '0;
         ncyc_q   <= '0;
         gsel_q   <= '0;
         notify_q <= 1'b0;
         level_q  <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         irq_q    <= 1'b0;
         state_q  <= ST_IDLE;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               A_TGT_NS:  tgt_q.ns  <= wr_data;
               A_TGT_SEC: tgt_q.sec <= wr_data;
               A_CYCLE:   cyc_q     <= wr_data[CW_W-1:0];
               A_PULSE:   pw_q      <= wr_data[PW_W-1:0];
               A_COUNT:   cnt_q     <= wr_data[CNT_W-1:0];
               A_CTRL: begin
                  if (!wr_data[1]) begin
                     notify_q <= wr_data[2];
                     gsel_q   <= wr_data[4 +: GS_W];
                  end
               end
               A_STAT: begin
                  if (wr_data[0]) done_q <= 1'b0;
                  if (wr_data[1]) err_q  <= 1'b0;
                  if (wr_data[2]) irq_q  <= 1'b0;
               end
               default: ;
            endcase
         end

         if (trig_rst) begin
            state_q <= ST_IDLE;
         end else if (arm) begin
            if (late) begin
               err_q   <= 1'b1;
               state_q <= ST_IDLE;
            end else begin
               nxt_q   <= tgt_q;
               ncyc_q  <= '0;
               state_q <= ST_WAIT;
            end
         end else begin
            case (state_q)
               ST_WAIT: begin
                  if (at_bound) begin
                     level_q <= 1'b1;
                     nxt_q   <= nxt_d;
                     hend_q  <= hend_d;
                     ncyc_q  <= CNT_W'(1);
                     state_q <= ST_RUN;
                  end
               end
               ST_RUN: begin
                  if (at_bound) begin
                     if (last_cyc) begin
                        level_q <= 1'b0;
                        done_q  <= 1'b1;
                        if (notify_q) irq_q <= 1'b1;
                        state_q <= ST_IDLE;
                     end else begin
                        level_q <= 1'b1;
                        nxt_q   <= nxt_d;
                        hend_q  <= hend_d;
                        if (cnt_q != '0) ncyc_q <= ncyc_q + CNT_W'(1);
                     end
                  end else if (at_hend) begin
                     level_q <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign level_o  = level_q;
   assign active_o = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign err_o    = err_q;
   assign irq_o    = irq_q;
   assign gsel_o   = gsel_q;

   // R2: a rise only follows a sampled time at or past the boundary
   p_rise_on_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level_q) |-> $past(at_bound));

   // R3: a fall only follows the high-time end or the final boundary
   p_fall_on_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(level_q) |-> $past(at_hend || at_bound));

   // R5: completion leaves the pin low and the unit idle
   p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (!level_q && !active_o));

   // R7: interrupt only with notify selected
   p_irq_notify_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> notify_q);

   // R8: a late start sets the error flag and stays idle
   p_late_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && late) |=> (err_o && !active_o));

   // R10: trigger reset stops the unit and holds the pin level
   p_trig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_rst |=> ($stable(level_q) && !active_o));

endmodule

// File: rtl/pulse_trig.sv
module pulse_trig
   import ptu_pkg::*;
#(
   parameter int NUM_UNITS = 3,
   parameter int NUM_PINS  = 4,
   parameter int CW_W      = 30,
   parameter int PW_W      = 24,
   parameter int CNT_W     = 16,
   localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int GS_W     = $clog2(NUM_PINS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [31:0]          now_sec,
   input  logic [31:0]          now_ns,
   input  logic                 wr_en,
   input  logic [UNIT_W-1:0]    wr_unit,
   input  logic [2:0]           wr_addr,
   input  logic [31:0]          wr_data,
   output logic [NUM_PINS-1:0]  gpio_out,
   output logic [NUM_UNITS-1:0] unit_active,
   output logic [NUM_UNITS-1:0] unit_done,
   output logic [NUM_UNITS-1:0] unit_err,
   output logic [NUM_UNITS-1:0] unit_irq
);

   generate
      if (NUM_UNITS < 1 || NUM_UNITS > 8) begin : g_bad_units
         $error("pulse_trig: NUM_UNITS must lie in 1..8");
      end
      if (NUM_PINS < 2 || NUM_PINS > 16) begin : g_bad_pins
         $error("pulse_trig: NUM_PINS must lie in 2..16");
      end
      if (PW_W + 3 > 30 || PW_W < 1) begin : g_bad_pw
         $error("pulse_trig: high-time field too wide");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("pulse_trig: CNT_W must lie in 1..32");
      end
   endgenerate

   ptu_time_t             now;
   logic [NUM_UNITS-1:0]  lvl;
   logic [GS_W-1:0]       gsel [NUM_UNITS];

   assign now.sec = now_sec;
   assign now.ns  = now_ns;

   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
         ptu_unit #(
            .CW_W (CW_W),
            .PW_W (PW_W),
            .CNT_W(CNT_W),
            .GS_W (GS_W)
         ) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .now     (now),
            .wr_en   (wr_en && (wr_unit == UNIT_W'(u))),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .level_o (lvl[u]),
            .active_o(unit_active[u]),
            .done_o  (unit_done[u]),
            .err_o   (unit_err[u]),
            .irq_o   (unit_irq[u]),
            .gsel_o  (gsel[u])
         );
      end
   endgenerate

   always_comb begin
      gpio_out = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (lvl[u] && (gsel[u] == GS_W'(p))) gpio_out[p] = 1'b1;
         end
      end
   end

   // R11: a high pin must be owned by a unit that is driving high
   p_pin_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (gpio_out != '0) |-> (lvl != '0));

endmodule

// File: tb/sim_pulse_trig.sv
module sim_pulse_trig;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] now_sec = '0;
   logic [31:0] now_ns = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_unit = '0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  gpio_out;
   logic [2:0]  unit_active, unit_done, unit_err, unit_irq;

   int n_chk = 0;
   int n_fail = 0;

   logic        jump_req = 1'b0;
   logic [31:0] jump_sec = '0, jump_ns = '0;

   pulse_trig u0 (
      .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
      .wr_en(wr_en), .wr_unit(wr_unit), .wr_addr(wr_addr), .wr_data(wr_data),
      .gpio_out(gpio_out), .unit_active(unit_active), .unit_done(unit_done),
      .unit_err(unit_err), .unit_irq(unit_irq)
   );

   always #10 clk = ~clk;

   // time-of-day model: 40 ns per clock
   always @(posedge clk) begin
      if (jump_req) begin
         now_sec <= jump_sec;
         now_ns  <= jump_ns;
      end else if (now_ns + 32'd40 >= 32'd1_000_000_000) begin
         now_sec <= now_sec + 32'd1;
         now_ns  <= now_ns + 32'd40 - 32'd1_000_000_000;
      end else begin
         now_ns  <= now_ns + 32'd40;
      end
   end

   function automatic longint tot(input logic [31:0] s, input logic [31:0] n);
      return longint'(s) * 64'd1000000000 + longint'(n);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int u, input int a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_unit = 2'(u);
      wr_addr = 3'(a);
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic jump(input logic [31:0] s, input logic [31:0] n);
      jump_req = 1'b1;
      jump_sec = s;
      jump_ns  = n;
      @(negedge clk);
      jump_req = 1'b0;
   endtask

   task automatic setup(input int u, input longint t, input int cyc, input int pw,
                        input int cnt, input logic [31:0] ctrl);
      wr(u, 0, 32'(t % 64'd1000000000));
      wr(u, 1, 32'(t / 64'd1000000000));
      wr(u, 2, 32'(cyc));
      wr(u, 3, 32'(pw));
      wr(u, 4, 32'(cnt));
      wr(u, 5, ctrl);
   endtask

   task automatic observe(input int pin, input int ncyc, output int rises,
                          output int hi1, output int per, output int ones,
                          output int other, output longint r1, output longint r2);
      logic prev;
      int   c1;
      prev = gpio_out[pin];
      rises = 0; hi1 = 0; per = -1; ones = 0; other = 0; r1 = -1; r2 = -1; c1 = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if ((gpio_out & ~(4'b1 << pin)) != 4'b0) other++;
         if (gpio_out[pin]) ones++;
         if (gpio_out[pin] && !prev) begin
            rises++;
            if (rises == 1) begin
               c1 = i;
               r1 = tot(now_sec, now_ns) - 40;
            end else if (rises == 2) begin
               per = i - c1;
               r2 = tot(now_sec, now_ns) - 40;
            end
         end
         if (gpio_out[pin] && rises == 1) hi1++;
         prev = gpio_out[pin];
      end
   endtask

   task automatic t_reset_state();
      chk(gpio_out == 4'b0,    "R1", "pins after reset",   longint'(gpio_out), 0);
      chk(unit_active == 3'b0, "R1", "active after reset", longint'(unit_active), 0);
      chk((unit_done | unit_err | unit_irq) == 3'b0, "R1", "flags after reset",
          longint'(unit_done | unit_err | unit_irq), 0);
   endtask

   task automatic t_finite_train();
      longint t;
      int rises, hi1, per, ones, other;
      longint r1, r2;
      t = tot(now_sec, now_ns) + 2000;
      setup(0, t, 400, 16, 3, 32'h5);
      chk(unit_active[0] == 1'b1, "R2", "armed unit active", longint'(unit_active[0]), 1);
      observe(0, 100, rises, hi1, per, ones, other, r1, r2);
      chk(r1 >= t && r1 - 40 < t, "R2", "first rise time", r1, t);
      chk(hi1 == 4,   "R3", "high cycles for 128 ns", hi1, 4);
      chk(per == 10,  "R4", "period cycles for 400 ns", per, 10);
      chk(rises == 3, "R5", "pulse count", rises, 3);
      chk(unit_done[0] == 1'b1,   "R5", "done set",      longint'(unit_done[0]), 1);
      chk(unit_active[0] == 1'b0, "R5", "idle at end",   longint'(unit_active[0]), 0);
      chk(gpio_out[0] == 1'b0,    "R5", "pin low at end", longint'(gpio_out[0]), 0);
      chk(unit_irq[0] == 1'b1,    "R7", "irq with notify", longint'(unit_irq[0]), 1);
   endtask

   task automatic t_flag_clear();
      wr(0, 6, 32'h0);
      chk(unit_done[0] == 1'b1, "R9", "zero write keeps done", longint'(unit_done[0]), 1);
      wr(0, 6, 32'h1);
      chk(unit_done[0] == 1'b0, "R9", "bit0 clears done", longint'(unit_done[0]), 0);
      chk(unit_irq[0] == 1'b1,  "R9", "bit0 keeps irq",   longint'(unit_irq[0]), 1);
      wr(0, 6, 32'h4);
      chk(unit_irq[0] == 1'b0,  "R9", "bit2 clears irq",  longint'(unit_irq[0]), 0);
   endtask

   task automatic t_short_pulse();
      longint t;
      int rises, hi1, per, ones, other;
      longint r1, r2;
      t = tot(now_sec, now_ns) + 2000;
      setup(0, t, 200, 5, 2, 32'h1);
      observe(0, 100, rises, hi1, per, ones, other, r1, r2);
      chk(hi1 == 1,   "R3", "high cycles for 40 ns", hi1, 1);
      chk(per == 5,   "R4", "period cycles for 200 ns", per, 5);
      chk(rises == 2, "R5", "two pulses", rises, 2);
      chk(unit_done[0] == 1'b1, "R7", "done without notify", longint'(unit_done[0]), 1);
      chk(unit_irq[0] == 1'b0,  "R7", "no irq without notify", longint'(unit_irq[0]), 0);
      wr(0, 6, 32'h1);
   endtask

   task automatic t_second_carry();
      longint t;
      int rises, hi1, per, ones, other;
      longint r1, r2;
      jump(32'd5, 32'd999_990_000);
      t = tot(32'd5, 32'd999_999_960);
      setup(2, t, 1000, 50, 2, 32'h35);
      observe(3, 320, rises, hi1, per, ones, other, r1, r2);
      chk(r1 == t,        "R2", "rise before rollover", r1, t);
      chk(r2 == t + 1000, "R4", "rise after rollover", r2, t + 1000);
      chk(per == 25,      "R4", "period across rollover", per, 25);
      chk(hi1 == 10,      "R3", "high cycles for 400 ns", hi1, 10);
      chk(rises == 2,     "R5", "pulses on pin 3", rises, 2);
      chk(other == 0,     "R11", "other pins stay low", other, 0);
      chk(unit_done[2] == 1'b1, "R11", "unit 2 done", longint'(unit_done[2]), 1);
      wr(2, 6, 32'h7);
   endtask

   task automatic t_late_start();
      int rises, hi1, per, ones, other;
      longint r1, r2;
      setup(1, 64'd0, 400, 10, 1, 32'h15);
      chk(unit_err[1] == 1'b1,    "R8", "error on late start", longint'(unit_err[1]), 1);
      chk(unit_active[1] == 1'b0, "R8", "not armed", longint'(unit_active[1]), 0);
      observe(1, 30, rises, hi1, per, ones, other, r1, r2);
      chk(ones == 0, "R8", "no pulse after late start", ones, 0);
      wr(1, 6, 32'h2);
      chk(unit_err[1] == 1'b0, "R9", "bit1 clears error", longint'(unit_err[1]), 0);
   endtask

   task automatic t_free_run_halt();
      longint t;
      int rises, hi1, per, ones, other;
      longint r1, r2;
      t = tot(now_sec, now_ns) + 2000;
      setup(1, t, 400, 25, 0, 32'h15);
      observe(1, 200, rises, hi1, per, ones, other, r1, r2);
      chk(rises >= 12, "R6", "endless train keeps going", rises, 12);
      chk(unit_done[1] == 1'b0,   "R6", "no done with count 0", longint'(unit_done[1]), 0);
      chk(unit_active[1] == 1'b1, "R6", "still active", longint'(unit_active[1]), 1);
      for (int i = 0; i < 20 && !gpio_out[1]; i++) @(negedge clk);
      chk(gpio_out[1] == 1'b1, "R10", "pin high before reset", longint'(gpio_out[1]), 1);
      wr(1, 5, 32'h2);
      chk(unit_active[1] == 1'b0, "R10", "reset clears active", longint'(unit_active[1]), 0);
      observe(1, 30, rises, hi1, per, ones, other, r1, r2);
      chk(ones == 30, "R10", "pin level held", ones, 30);
      chk(unit_irq[1] == 1'b0, "R10", "no irq from reset", longint'(unit_irq[1]), 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_finite_train();
      t_flag_clear();
      t_short_pulse();
      t_second_carry();
      t_late_start();
      t_free_run_halt();
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

endmodule